// File: doc/BRIEF.md
# Device Reset Sequencer

This block takes the asynchronous, active-low reset pin of a switch device and turns it into an internal core reset and a ready indication. A fall of the pin drops the core into reset, which is its lowest-power state, and clears the ready output without waiting for a clock edge. The release of the pin passes through a synchronizer. The internal reset then stays asserted until a minimum hold time, counted from the fall of the pin, has elapsed. A fixed idle window follows, and only after it does the block declare the device ready.

Until ready is high, the block shields the core from its surroundings. Host chip-select is forced inactive, the per-group update-enable inputs are seen as low, every serial lane is forced into power-down, and the pattern generators and checkers are held off. In the cycle ready rises, the block emits a one-cycle load-defaults strobe for the register file. It also reports whether the last reset pulse was shorter than the minimum width. All timings are parameters in clock cycles, so a bench can run a shortened configuration.

Top module: `devrst_seq`

## Requirements
- R1: A low level on `rst_pin_n` drives `core_rst_n_o` and `ready_o` low at once, with no clock edge needed.
- R2: For a pulse that is low across L rising clock edges, `core_rst_n_o` rises at rising edge E = max(L+3, MIN_CYC), counted from the first edge after the fall. A short pulse therefore still holds the core in reset for MIN_CYC edges.
- R3: The release of the pin is synchronized through two flops, so the core reset cannot end before the third rising edge after the pin returns high.
- R4: `ready_o` rises exactly IDLE_CYC rising edges after `core_rst_n_o` rises (edge E+IDLE_CYC).
- R5: While `ready_o` is low, `host_cs_n_o` is 1 whatever `host_cs_n_i` is. While `ready_o` is high, it equals `host_cs_n_i`.
- R6: While `ready_o` is low, `upd_en_o` is all zeros. While `ready_o` is high, bit g equals `upd_en_i[g]`.
- R7: While `ready_o` is low, `lane_pd_o` is all ones (1 = lane powered down) and `pat_en_o` is all zeros (1 = pattern engine on). While `ready_o` is high, both pass the matching config inputs.
- R8: `defaults_ld_o` is high for exactly the one cycle in which `ready_o` first reads high after a reset, and is low at all other times.
- R9: At each release, `short_rst_o` is set if L+2 < MIN_CYC and cleared otherwise. It then holds that value through the idle window and the ready state, until the next release.
- R10: A new fall of the pin during the idle window restarts the sequence from the held state, with R2 and R4 timed from the new fall. A fall in the same cycle in which the idle count would expire wins: neither `ready_o` nor `defaults_ld_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_pin_n | input | 1 | External reset pin, active low, asynchronous |
| host_cs_n_i | input | 1 | Host chip-select from the pad, active low |
| upd_en_i | input | GROUPS | Per-group update-enable inputs |
| lane_pd_cfg_i | input | LANES | Register-file lane power-down settings |
| pat_en_cfg_i | input | PATS | Register-file pattern-engine enables |
| host_cs_n_o | output | 1 | Gated chip-select toward the register bridge |
| upd_en_o | output | GROUPS | Gated update enables |
| lane_pd_o | output | LANES | Lane power-down controls |
| pat_en_o | output | PATS | Pattern-engine enables |
| core_rst_n_o | output | 1 | Internal core reset, active low |
| ready_o | output | 1 | Device operational |
| defaults_ld_o | output | 1 | One-cycle strobe to load register defaults |
| short_rst_o | output | 1 | Last reset pulse was shorter than the minimum |

## Verification
Two events can fall in the same cycle: the idle counter reaching its end, and a new fall of the reset pin. The bench lowers the pin on the falling clock edge just before the edge at which ready would rise. It then expects ready and the load-defaults strobe to stay low, and expects a full new sequence timed from that fall. A sweep over every pulse width from 1 to 40 edges places the release on each side of the minimum-width boundary. For each width, the bench computes the core-release edge, the ready edge and the short-pulse flag from max(L+3, MIN_CYC).

// File: rtl/devrst_pkg.sv
package devrst_pkg;

  typedef enum logic [1:0] {
    ST_HELD  = 2'd0,
    ST_IDLE  = 2'd1,
    ST_READY = 2'd2
  } seq_state_e;

  // counter width able to hold the value maxv
  function automatic int unsigned cnt_width(input int unsigned maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction

  // rising edge (counted from the pin fall) at which the core reset ends
  function automatic int unsigned exit_edge(input int unsigned low_edges,
                                            input int unsigned min_cyc);
    return (low_edges + 3 > min_cyc) ? low_edges + 3 : min_cyc;
  endfunction

endpackage

// File: rtl/devrst_sync.sv
module devrst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rel_n
);
  logic [STAGES-1:0] sh_q;

  // clears at once on the pin, releases after STAGES edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rel_n = sh_q[STAGES-1];
endmodule

// File: rtl/devrst_ctr.sv
module devrst_ctr #(
  parameter int unsigned MAXV = 16,
  localparam int unsigned W = devrst_pkg::cnt_width(MAXV)
) (
  input  logic         clk,
  input  logic         run,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = W'(MAXV);
  logic [W-1:0] q;

  // no pin reset: the count must keep running while the pin is low
  always_ff @(posedge clk) begin
    if (!run)          q <= '0;
    else if (q != TOP) q <= q + 1'b1;
  end

  assign cnt = q;
endmodule

// File: rtl/devrst_gate.sv
module devrst_gate #(
  parameter int GROUPS = 8,
  parameter int LANES  = 8,
  parameter int PATS   = 4
) (
  input  logic              open_i,
  input  logic              cs_n_i,
  input  logic [GROUPS-1:0] upd_i,
  input  logic [LANES-1:0]  lane_cfg_i,
  input  logic [PATS-1:0]   pat_cfg_i,
  output logic              cs_n_o,
  output logic [GROUPS-1:0] upd_o,
  output logic [LANES-1:0]  lane_o,
  output logic [PATS-1:0]   pat_o
);
  assign cs_n_o = cs_n_i | ~open_i;

  for (genvar g = 0; g < GROUPS; g++) begin : g_upd
    assign upd_o[g] = upd_i[g] & open_i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_o[l] = lane_cfg_i[l] | ~open_i;
  end

  for (genvar p = 0; p < PATS; p++) begin : g_pat
    assign pat_o[p] = pat_cfg_i[p] & open_i;
  end
endmodule

// File: rtl/devrst_seq.sv
module devrst_seq #(
  parameter int unsigned MIN_CYC  = 1_000_000,
  parameter int unsigned IDLE_CYC = 5_000,
  parameter int          GROUPS   = 8,
  parameter int          LANES    = 8,
  parameter int          PATS     = 4
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              host_cs_n_i,
  input  logic [GROUPS-1:0] upd_en_i,
  input  logic [LANES-1:0]  lane_pd_cfg_i,
  input  logic [PATS-1:0]   pat_en_cfg_i,
  output logic              host_cs_n_o,
  output logic [GROUPS-1:0] upd_en_o,
  output logic [LANES-1:0]  lane_pd_o,
  output logic [PATS-1:0]   pat_en_o,
  output logic              core_rst_n_o,
  output logic              ready_o,
  output logic              defaults_ld_o,
  output logic              short_rst_o
);
  import devrst_pkg::*;

  localparam int unsigned HW = cnt_width(MIN_CYC);
  localparam int unsigned IW = cnt_width(IDLE_CYC);
  localparam logic [HW-1:0] HOLD_LAST = HW'(MIN_CYC - 1);
  localparam logic [HW-1:0] HOLD_FULL = HW'(MIN_CYC);
  localparam logic [IW-1:0] IDLE_LAST = IW'(IDLE_CYC - 1);

  seq_state_e  st_q;
  logic        rel_n;
  logic        seen_q, core_q, rdy_q, ld_q, short_q;
  logic [HW-1:0] hold_cnt;
  logic [IW-1:0] idle_cnt;

  // named internal events
  logic evt_release, evt_hold_done, evt_idle_done;

  devrst_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .arst_n (rst_pin_n),
    .rel_n  (rel_n)
  );

  devrst_ctr #(.MAXV(MIN_CYC)) u_hold (
    .clk (clk),
    .run (st_q == ST_HELD),
    .cnt (hold_cnt)
  );

  devrst_ctr #(.MAXV(IDLE_CYC)) u_idle (
    .clk (clk),
    .run (st_q == ST_IDLE),
    .cnt (idle_cnt)
  );

  assign evt_release   = rel_n & ~seen_q;
  assign evt_hold_done = (st_q == ST_HELD) && rel_n && (hold_cnt >= HOLD_LAST);
  assign evt_idle_done = (st_q == ST_IDLE) && (idle_cnt >= IDLE_LAST);

  always_ff @(posedge clk or negedge rel_n) begin
    if (!rel_n) begin
      st_q   <= ST_HELD;
      seen_q <= 1'b0;
      core_q <= 1'b0;
      rdy_q  <= 1'b0;
      ld_q   <= 1'b0;
    end else begin
      seen_q <= 1'b1;
      ld_q   <= 1'b0;
      unique case (st_q)
        ST_HELD: if (evt_hold_done) begin
          st_q   <= ST_IDLE;
          core_q <= 1'b1;
        end
        ST_IDLE: if (evt_idle_done) begin
          st_q  <= ST_READY;
          rdy_q <= 1'b1;
          ld_q  <= 1'b1;
        end
        default: st_q <= ST_READY;
      endcase
    end
  end

  // width verdict taken once per release, kept until the next one
  always_ff @(posedge clk) begin
    if (evt_release) short_q <= (hold_cnt < HOLD_FULL);
  end

  devrst_gate #(.GROUPS(GROUPS), .LANES(LANES), .PATS(PATS)) u_gate (
    .open_i     (rdy_q),
    .cs_n_i     (host_cs_n_i),
    .upd_i      (upd_en_i),
    .lane_cfg_i (lane_pd_cfg_i),
    .pat_cfg_i  (pat_en_cfg_i),
    .cs_n_o     (host_cs_n_o),
    .upd_o      (upd_en_o),
    .lane_o     (lane_pd_o),
    .pat_o      (pat_en_o)
  );

  assign core_rst_n_o  = core_q;
  assign ready_o       = rdy_q;
  assign defaults_ld_o = ld_q;
  assign short_rst_o   = short_q;
endmodule

// File: rtl/devrst_seq_chk.sv
module devrst_seq_chk #(
  parameter int GROUPS = 8,
  parameter int LANES  = 8,
  parameter int PATS   = 4
) (
  input logic              clk,
  input logic              rst_pin_n,
  input logic              host_cs_n_o,
  input logic [GROUPS-1:0] upd_en_o,
  input logic [LANES-1:0]  lane_pd_o,
  input logic [PATS-1:0]   pat_en_o,
  input logic              core_rst_n_o,
  input logic              ready_o,
  input logic              defaults_ld_o,
  input logic              evt_idle_done
);
  // R1
  ready_needs_core_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ready_o |-> core_rst_n_o);

  // R4
  idle_to_ready_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    evt_idle_done |=> ready_o);

  // R5
  host_block_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    !ready_o |-> host_cs_n_o);

  // R6
  upd_block_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    !ready_o |-> (upd_en_o == '0));

  // R7
  lane_force_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    !ready_o |-> ((&lane_pd_o) && (pat_en_o == '0)));

  // R8
  ld_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(ready_o) |-> defaults_ld_o);

  // R8
  ld_single_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    defaults_ld_o |=> !defaults_ld_o);

  // R10
  ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ready_o |=> ready_o);
endmodule

bind devrst_seq devrst_seq_chk #(.GROUPS(GROUPS), .LANES(LANES), .PATS(PATS)) u_chk (
  .clk           (clk),
  .rst_pin_n     (rst_pin_n),
  .host_cs_n_o   (host_cs_n_o),
  .upd_en_o      (upd_en_o),
  .lane_pd_o     (lane_pd_o),
  .pat_en_o      (pat_en_o),
  .core_rst_n_o  (core_rst_n_o),
  .ready_o       (ready_o),
  .defaults_ld_o (defaults_ld_o),
  .evt_idle_done (evt_idle_done)
);

// File: tb/sim_devrst_seq.sv
`timescale 1ns/1ps
module sim_devrst_seq;
  localparam int MIN  = 24;
  localparam int IDLE = 10;
  localparam int G = 4, LN = 6, P = 3;

  logic clk = 1'b0;
  logic rst_pin_n = 1'b0;
  logic host_cs_n_i = 1'b0;
  logic [G-1:0]  upd_en_i = 4'hA;
  logic [LN-1:0] lane_pd_cfg_i = 6'b010110;
  logic [P-1:0]  pat_en_cfg_i = 3'b101;
  logic host_cs_n_o, core_rst_n_o, ready_o, defaults_ld_o, short_rst_o;
  logic [G-1:0] upd_en_o;
  logic [LN-1:0] lane_pd_o;
  logic [P-1:0] pat_en_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  devrst_seq #(.MIN_CYC(MIN), .IDLE_CYC(IDLE), .GROUPS(G), .LANES(LN), .PATS(P)) u0 (
    .clk, .rst_pin_n, .host_cs_n_i, .upd_en_i, .lane_pd_cfg_i, .pat_en_cfg_i,
    .host_cs_n_o, .upd_en_o, .lane_pd_o, .pat_en_o,
    .core_rst_n_o, .ready_o, .defaults_ld_o, .short_rst_o
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // gated outputs while not ready: R5 R6 R7
  task automatic chk_blocked;
    chk(host_cs_n_o == 1'b1, "R5 cs blocked", host_cs_n_o, 1);
    chk(upd_en_o == '0, "R6 upd blocked", upd_en_o, 0);
    chk(lane_pd_o == '1, "R7 lanes down", lane_pd_o, {LN{1'b1}});
    chk(pat_en_o == '0, "R7 pattern off", pat_en_o, 0);
  endtask

  task automatic chk_open;
    chk(host_cs_n_o == host_cs_n_i, "R5 cs pass", host_cs_n_o, host_cs_n_i);
    chk(upd_en_o == upd_en_i, "R6 upd pass", upd_en_o, upd_en_i);
    chk(lane_pd_o == lane_pd_cfg_i, "R7 lane pass", lane_pd_o, lane_pd_cfg_i);
    chk(pat_en_o == pat_en_cfg_i, "R7 pat pass", pat_en_o, pat_en_cfg_i);
  endtask

  // called at a negedge; returns at the negedge after the core-release edge
  task automatic pulse(input int L);
    int e;
    e = (L + 3 > MIN) ? L + 3 : MIN;
    rst_pin_n = 1'b0;
    #1;
    chk(ready_o == 1'b0, "R1 ready async low", ready_o, 0);
    chk(core_rst_n_o == 1'b0, "R1 core async low", core_rst_n_o, 0);
    @(negedge clk);
    chk(ready_o == 1'b0 && defaults_ld_o == 1'b0, "R10 no ready after fall",
        {ready_o, defaults_ld_o}, 0);
    repeat (L - 1) @(negedge clk);
    rst_pin_n = 1'b1;
    repeat (e - 1 - L) @(negedge clk);
    chk(core_rst_n_o == 1'b0, "R2 R3 core still held", core_rst_n_o, 0);
    @(negedge clk);
    chk(core_rst_n_o == 1'b1, "R2 R3 core released", core_rst_n_o, 1);
  endtask

  task automatic to_ready(input int L);
    repeat (IDLE - 1) @(negedge clk);
    chk(ready_o == 1'b0, "R4 not yet ready", ready_o, 0);
    chk_blocked();
    @(negedge clk);
    chk(ready_o == 1'b1, "R4 ready", ready_o, 1);
    chk(defaults_ld_o == 1'b1, "R8 load strobe", defaults_ld_o, 1);
    chk(short_rst_o == ((L + 2) < MIN), "R9 short flag", short_rst_o, (L + 2) < MIN);
    chk_open();
    @(negedge clk);
    chk(defaults_ld_o == 1'b0, "R8 strobe one cycle", defaults_ld_o, 0);
    chk(ready_o == 1'b1, "R4 ready stays", ready_o, 1);
  endtask

  initial begin
    repeat (100_000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    #1;
    chk(ready_o == 1'b0 && core_rst_n_o == 1'b0, "R1 reset state", {ready_o, core_rst_n_o}, 0);
    chk_blocked();
    repeat (40) @(negedge clk);
    rst_pin_n = 1'b1;
    repeat (3 + IDLE + 4) @(negedge clk);
    chk(ready_o == 1'b1, "R4 power-up ready", ready_o, 1);
    chk(short_rst_o == 1'b0, "R9 power-up long", short_rst_o, 0);

    // width sweep across the minimum boundary
    for (int L = 1; L <= 40; L++) begin
      host_cs_n_i = L[0];
      upd_en_i = G'(L * 5);
      lane_pd_cfg_i = LN'(L * 7);
      pat_en_cfg_i = P'(L);
      pulse(L);
      to_ready(L);
      repeat (2) @(negedge clk);
    end

    // R10: restart from inside the idle window
    pulse(40);
    repeat (3) @(negedge clk);
    pulse(5);
    to_ready(5);

    // R10: fall in the same cycle the idle count would expire
    pulse(30);
    repeat (IDLE - 1) @(negedge clk);
    pulse(30);
    to_ready(30);

    // R9: short flag persists then clears on a full pulse
    pulse(3);
    to_ready(3);
    repeat (5) @(negedge clk);
    chk(short_rst_o == 1'b1, "R9 flag held", short_rst_o, 1);
    pulse(35);
    to_ready(35);

    done = 1;
    summary();
  end
endmodule